// File: doc/BRIEF.md
# Load Issue Gate with Blocked-Load Record

This block sits between the load execution lanes of an out-of-order core and the data cache. Every cycle each lane may present one load together with its load-queue index, its age tag (a sequence number where smaller means older), and three attributes: uncacheable, at-commit and load-locked. The gate decides, lane by lane and within the same cycle, whether the load goes to the cache, must be replayed later, or has run into a blocked cache.

An uncacheable load may only go out when it sits at the load-queue head and is ready to commit. Any other uncacheable load is sent back for replay and flagged as faulting. Loads that pass this test take one of a fixed number of cache ports. The port count starts from zero at the beginning of every cycle, and lane 0 has first claim on a port. A load that finds every port taken is replayed without a fault. If the cache reports itself blocked, a load that holds a port is marked blocked instead of issuing.

The block keeps a single record of a blocked load for the squash and restart logic. The record holds the oldest such load, and a younger blocked load never displaces an older one that is already recorded. Two side inputs act on the record: one drops it and one marks it as handled. A queue-full flag is also derived from the load and store occupancy counts.

Top module: `load_issue_gate`

## Requirements
- R1: A valid uncacheable load whose index differs from `lq_head`, or whose at-commit bit is 0, gets `resched_o`=1 and `fault_o`=1. It neither issues nor takes a port.
- R2: An uncacheable load whose index equals `lq_head` and whose at-commit bit is 1 is treated exactly like a cacheable load.
- R3: An issuing load drives `cmd_locked_o`=1 when its load-locked bit is set and 0 when it is clear (plain read). `cmd_locked_o` is 0 on any lane that does not issue.
- R4: Lanes claim ports in ascending lane order. Each lane that passes the R1 test takes a port while fewer than PORTS (default 2) are in use. A lane that passes R1 but finds all ports taken gets `resched_o`=1 with `fault_o`=0. `used_ports_o` gives the number of ports taken in the current cycle, and the count restarts from 0 every cycle.
- R5: When `cache_blocked`=1, a lane that took a port gets `blocked_o`=1 and does not issue. When `cache_blocked`=0 it gets `issue_o`=1.
- R6: After a cycle with at least one blocked lane, if the record is empty or the smallest blocked sequence number is not larger than the recorded one, then on the next cycle `blk_flag_o`=1, `blk_handled_o`=0 and `blk_seq_o` holds that smallest sequence number.
- R7: If the record holds a sequence number strictly smaller than every load blocked this cycle, the record keeps its sequence number, flag and handled bit unchanged.
- R8: In a cycle with no blocked lane, `blk_clear`=1 clears `blk_flag_o` on the next cycle. In a cycle with a blocked lane the clear input is ignored.
- R9: In a cycle with no blocked lane, `blk_set_handled`=1 while `blk_flag_o`=1 sets `blk_handled_o` on the next cycle. It has no effect while the flag is 0.
- R10: `full_o`=1 exactly when `lq_count` >= LQ_SLOTS-1 or `sq_count` >= SQ_SLOTS-1 (default 15 for both).
- R11: After reset `blk_flag_o`, `blk_handled_o` and `blk_seq_o` are all 0.
- R12: A lane whose valid bit is 0 drives none of `issue_o`, `resched_o`, `blocked_o`, `fault_o`, `cmd_locked_o` and takes no port. Each lane asserts at most one of `issue_o`, `resched_o`, `blocked_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | LANES | Load present on each lane |
| ld_idx | input | LANES*IDXW | Load-queue index per lane, lane i at bits [i*IDXW +: IDXW] |
| ld_seq | input | LANES*SEQW | Sequence number per lane (smaller is older) |
| ld_uncached | input | LANES | Load targets uncacheable memory |
| ld_at_commit | input | LANES | Load is ready to commit |
| ld_locked | input | LANES | Load-locked access |
| lq_head | input | IDXW | Current load-queue head index |
| cache_blocked | input | 1 | Cache cannot accept accesses this cycle |
| lq_count | input | LCW | Loads held in the load queue |
| sq_count | input | SCW | Stores held in the store queue |
| blk_clear | input | 1 | Drop the blocked-load record |
| blk_set_handled | input | 1 | Mark the recorded blocked load as handled |
| issue_o | output | LANES | Load is sent to the cache |
| cmd_locked_o | output | LANES | Command of an issued load: 1 load-locked, 0 read |
| resched_o | output | LANES | Load must be replayed |
| fault_o | output | LANES | Uncacheable load rejected away from head or commit |
| blocked_o | output | LANES | Load hit a blocked cache |
| used_ports_o | output | CNTW | Cache ports taken this cycle |
| full_o | output | 1 | Load or store queue at its limit |
| blk_flag_o | output | 1 | A blocked load is recorded |
| blk_handled_o | output | 1 | The recorded blocked load has been handled |
| blk_seq_o | output | SEQW | Sequence number of the recorded blocked load |

## Verification
The hardest situation to reach is a cycle where several lanes are blocked at once while an older load is already recorded, so that the record has to both pick the minimum among the lanes and compare it against the stored age. A clear or set-handled request arriving in that same cycle makes it harder still. The stimulus runs phases in which `cache_blocked` is held high most of the time and sequence numbers are drawn from a narrow range, which makes ties and near ties common. Directed cycles then place a block with an older tag ahead of one with a younger tag, test equal tags, and overlap clear and set-handled with fresh blocks.

// File: rtl/load_issue_gate_pkg.sv
package load_issue_gate_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_ISSUE   = 2'd1,
    ACT_REPLAY  = 2'd2,
    ACT_BLOCKED = 2'd3
  } lane_act_e;

  // Uncacheable load that is not both at the queue head and ready to commit.
  function automatic logic uc_reject(input logic uncached,
                                     input logic at_commit,
                                     input logic at_head);
    return uncached && !(at_head && at_commit);
  endfunction

  // Occupancy at or beyond the usable limit (one slot held back).
  function automatic logic at_limit(input logic [31:0] count,
                                    input logic [31:0] slots);
    return count >= (slots - 32'd1);
  endfunction

  // Age comparison: a is strictly older than b.
  function automatic logic strictly_older(input logic [31:0] a,
                                          input logic [31:0] b);
    return a < b;
  endfunction

endpackage

// File: rtl/load_issue_lane.sv
module load_issue_lane
  import load_issue_gate_pkg::*;
#(
  parameter int IDXW  = 4,
  parameter int CNTW  = 2,
  parameter int PORTS = 2
) (
  input  logic            valid,
  input  logic [IDXW-1:0] idx,
  input  logic [IDXW-1:0] head,
  input  logic            uncached,
  input  logic            at_commit,
  input  logic            locked,
  input  logic            cache_blocked,
  input  logic [CNTW-1:0] used_in,
  output logic [CNTW-1:0] used_out,
  output lane_act_e       act,
  output logic            cmd_locked,
  output logic            fault
);

  localparam logic [CNTW-1:0] PortLimit = CNTW'(PORTS);

  logic rejected;
  logic ports_gone;

  always_comb begin
    rejected   = uc_reject(uncached, at_commit, idx == head);
    ports_gone = (used_in == PortLimit);
    used_out   = used_in;
    act        = ACT_IDLE;
    cmd_locked = 1'b0;
    fault      = 1'b0;
    if (valid) begin
      if (rejected) begin
        act   = ACT_REPLAY;
        fault = 1'b1;
      end else if (ports_gone) begin
        act = ACT_REPLAY;
      end else begin
        used_out = used_in + CNTW'(1);
        if (cache_blocked) begin
          act = ACT_BLOCKED;
        end else begin
          act        = ACT_ISSUE;
          cmd_locked = locked;
        end
      end
    end
  end

endmodule

// File: rtl/load_block_oldest.sv
module load_block_oldest #(
  parameter int LANES = 3,
  parameter int SEQW  = 8
) (
  input  logic [LANES-1:0]      blocked,
  input  logic [LANES*SEQW-1:0] seq,
  output logic                  any,
  output logic [SEQW-1:0]       oldest
);

  always_comb begin
    any    = 1'b0;
    oldest = '0;
    for (int i = 0; i < LANES; i++) begin
      if (blocked[i] && (!any || seq[i*SEQW +: SEQW] < oldest)) begin
        any    = 1'b1;
        oldest = seq[i*SEQW +: SEQW];
      end
    end
  end

endmodule

// File: rtl/load_block_record.sv
module load_block_record
  import load_issue_gate_pkg::*;
#(
  parameter int SEQW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            new_v,
  input  logic [SEQW-1:0] new_seq,
  input  logic            clear,
  input  logic            set_handled,
  output logic            flag,
  output logic            handled,
  output logic [SEQW-1:0] seq
);

  logic keep_older;
  assign keep_older = flag && strictly_older(32'(seq), 32'(new_seq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      handled <= 1'b0;
      seq     <= '0;
    end else if (new_v) begin
      if (!keep_older) begin
        flag    <= 1'b1;
        handled <= 1'b0;
        seq     <= new_seq;
      end
    end else begin
      if (clear)
        flag <= 1'b0;
      if (set_handled && flag)
        handled <= 1'b1;
    end
  end

endmodule

// File: rtl/load_issue_gate.sv
module load_issue_gate
  import load_issue_gate_pkg::*;
#(
  parameter int LANES    = 3,
  parameter int PORTS    = 2,
  parameter int LQ_SLOTS = 16,
  parameter int SQ_SLOTS = 16,
  parameter int SEQW     = 8,
  localparam int IDXW    = $clog2(LQ_SLOTS),
  localparam int LCW     = $clog2(LQ_SLOTS + 1),
  localparam int SCW     = $clog2(SQ_SLOTS + 1),
  localparam int CNTW    = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      ld_valid,
  input  logic [LANES*IDXW-1:0] ld_idx,
  input  logic [LANES*SEQW-1:0] ld_seq,
  input  logic [LANES-1:0]      ld_uncached,
  input  logic [LANES-1:0]      ld_at_commit,
  input  logic [LANES-1:0]      ld_locked,
  input  logic [IDXW-1:0]       lq_head,
  input  logic                  cache_blocked,
  input  logic [LCW-1:0]        lq_count,
  input  logic [SCW-1:0]        sq_count,
  input  logic                  blk_clear,
  input  logic                  blk_set_handled,
  output logic [LANES-1:0]      issue_o,
  output logic [LANES-1:0]      cmd_locked_o,
  output logic [LANES-1:0]      resched_o,
  output logic [LANES-1:0]      fault_o,
  output logic [LANES-1:0]      blocked_o,
  output logic [CNTW-1:0]       used_ports_o,
  output logic                  full_o,
  output logic                  blk_flag_o,
  output logic                  blk_handled_o,
  output logic [SEQW-1:0]       blk_seq_o
);

  // Port usage passed from lane to lane; entry 0 is the cycle start.
  logic [CNTW-1:0] used_chain [LANES+1];
  lane_act_e       lane_act   [LANES];

  // Named internal events for the checker.
  logic            new_blk_v;
  logic [SEQW-1:0] new_blk_seq;

  assign used_chain[0] = '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    load_issue_lane #(
      .IDXW (IDXW),
      .CNTW (CNTW),
      .PORTS(PORTS)
    ) u_lane (
      .valid        (ld_valid[g]),
      .idx          (ld_idx[g*IDXW +: IDXW]),
      .head         (lq_head),
      .uncached     (ld_uncached[g]),
      .at_commit    (ld_at_commit[g]),
      .locked       (ld_locked[g]),
      .cache_blocked(cache_blocked),
      .used_in      (used_chain[g]),
      .used_out     (used_chain[g+1]),
      .act          (lane_act[g]),
      .cmd_locked   (cmd_locked_o[g]),
      .fault        (fault_o[g])
    );

    assign issue_o[g]   = (lane_act[g] == ACT_ISSUE);
    assign resched_o[g] = (lane_act[g] == ACT_REPLAY);
    assign blocked_o[g] = (lane_act[g] == ACT_BLOCKED);
  end

  assign used_ports_o = used_chain[LANES];
  assign full_o = at_limit(32'(lq_count), 32'(LQ_SLOTS)) ||
                  at_limit(32'(sq_count), 32'(SQ_SLOTS));

  load_block_oldest #(
    .LANES(LANES),
    .SEQW (SEQW)
  ) u_oldest (
    .blocked(blocked_o),
    .seq    (ld_seq),
    .any    (new_blk_v),
    .oldest (new_blk_seq)
  );

  load_block_record #(
    .SEQW(SEQW)
  ) u_record (
    .clk        (clk),
    .rst_n      (rst_n),
    .new_v      (new_blk_v),
    .new_seq    (new_blk_seq),
    .clear      (blk_clear),
    .set_handled(blk_set_handled),
    .flag       (blk_flag_o),
    .handled    (blk_handled_o),
    .seq        (blk_seq_o)
  );

endmodule

// File: rtl/load_issue_gate_chk.sv
module load_issue_gate_chk #(
  parameter int LANES    = 3,
  parameter int PORTS    = 2,
  parameter int LQ_SLOTS = 16,
  parameter int SQ_SLOTS = 16,
  parameter int SEQW     = 8,
  parameter int LCW      = 5,
  parameter int SCW      = 5,
  parameter int CNTW     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] ld_valid,
  input logic [LANES-1:0] ld_locked,
  input logic [LCW-1:0]   lq_count,
  input logic [SCW-1:0]   sq_count,
  input logic             blk_clear,
  input logic             blk_set_handled,
  input logic [LANES-1:0] issue_o,
  input logic [LANES-1:0] cmd_locked_o,
  input logic [LANES-1:0] resched_o,
  input logic [LANES-1:0] fault_o,
  input logic [LANES-1:0] blocked_o,
  input logic [CNTW-1:0]  used_ports_o,
  input logic             full_o,
  input logic             blk_flag_o,
  input logic             blk_handled_o,
  input logic [SEQW-1:0]  blk_seq_o,
  input logic             new_blk_v,
  input logic [SEQW-1:0]  new_blk_seq
);

  p_fault_resched_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o & ~resched_o) == '0);

  p_port_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    used_ports_o <= CNTW'(PORTS));

  p_blocked_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|blocked_o) |=> blk_flag_o);

  p_keep_older_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_flag_o && new_blk_v && (blk_seq_o < new_blk_seq)) |=> $stable(blk_seq_o));

  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_clear && !new_blk_v) |=> !blk_flag_o);

  p_handled_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_set_handled && blk_flag_o && !new_blk_v) |=> blk_handled_o);

  p_full_lq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lq_count) >= LQ_SLOTS - 1) |-> full_o);

  p_full_sq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sq_count) >= SQ_SLOTS - 1) |-> full_o);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_one_action_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({issue_o[g], resched_o[g], blocked_o[g]}));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid[g] |-> !(issue_o[g] || resched_o[g] || blocked_o[g] || fault_o[g]));

    p_locked_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_locked_o[g] |-> (issue_o[g] && ld_locked[g]));
  end

endmodule

bind load_issue_gate load_issue_gate_chk #(
  .LANES   (LANES),
  .PORTS   (PORTS),
  .LQ_SLOTS(LQ_SLOTS),
  .SQ_SLOTS(SQ_SLOTS),
  .SEQW    (SEQW),
  .LCW     (LCW),
  .SCW     (SCW),
  .CNTW    (CNTW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ld_valid       (ld_valid),
  .ld_locked      (ld_locked),
  .lq_count       (lq_count),
  .sq_count       (sq_count),
  .blk_clear      (blk_clear),
  .blk_set_handled(blk_set_handled),
  .issue_o        (issue_o),
  .cmd_locked_o   (cmd_locked_o),
  .resched_o      (resched_o),
  .fault_o        (fault_o),
  .blocked_o      (blocked_o),
  .used_ports_o   (used_ports_o),
  .full_o         (full_o),
  .blk_flag_o     (blk_flag_o),
  .blk_handled_o  (blk_handled_o),
  .blk_seq_o      (blk_seq_o),
  .new_blk_v      (new_blk_v),
  .new_blk_seq    (new_blk_seq)
);

// File: tb/load_issue_gate_test.sv
module load_issue_gate_test;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 3;
  localparam int PORTS = 2;
  localparam int SLOTS = 16;
  localparam int SEQW  = 8;
  localparam int IDXW  = 4;
  localparam int LCW   = 5;
  localparam int CNTW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0]      ld_valid = '0;
  logic [LANES*IDXW-1:0] ld_idx = '0;
  logic [LANES*SEQW-1:0] ld_seq = '0;
  logic [LANES-1:0]      ld_uncached = '0;
  logic [LANES-1:0]      ld_at_commit = '0;
  logic [LANES-1:0]      ld_locked = '0;
  logic [IDXW-1:0]       lq_head = '0;
  logic                  cache_blocked = 1'b0;
  logic [LCW-1:0]        lq_count = '0;
  logic [LCW-1:0]        sq_count = '0;
  logic                  blk_clear = 1'b0;
  logic                  blk_set_handled = 1'b0;
  logic [LANES-1:0]      issue_o, cmd_locked_o, resched_o, fault_o, blocked_o;
  logic [CNTW-1:0]       used_ports_o;
  logic                  full_o, blk_flag_o, blk_handled_o;
  logic [SEQW-1:0]       blk_seq_o;

  load_issue_gate uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_seq(ld_seq),
    .ld_uncached(ld_uncached), .ld_at_commit(ld_at_commit), .ld_locked(ld_locked),
    .lq_head(lq_head), .cache_blocked(cache_blocked), .lq_count(lq_count),
    .sq_count(sq_count), .blk_clear(blk_clear), .blk_set_handled(blk_set_handled),
    .issue_o(issue_o), .cmd_locked_o(cmd_locked_o), .resched_o(resched_o),
    .fault_o(fault_o), .blocked_o(blocked_o), .used_ports_o(used_ports_o),
    .full_o(full_o), .blk_flag_o(blk_flag_o), .blk_handled_o(blk_handled_o),
    .blk_seq_o(blk_seq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Reference record state (bench view)
  bit       m_flag = 0, m_hand = 0;
  int       m_seq = 0;
  bit       n_flag = 0, n_hand = 0;
  int       n_seq = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lane_idx(input int i);
    return int'(ld_idx[i*IDXW +: IDXW]);
  endfunction

  function automatic int lane_seq(input int i);
    return int'(ld_seq[i*SEQW +: SEQW]);
  endfunction

  // Check record outputs against the reference state.
  task automatic check_record(input string tag);
    chk(blk_flag_o == m_flag, {tag, " flag"}, int'(blk_flag_o), int'(m_flag));
    chk(blk_handled_o == m_hand, {tag, " handled"}, int'(blk_handled_o), int'(m_hand));
    if (m_flag)
      chk(int'(blk_seq_o) == m_seq, {tag, " seq"}, int'(blk_seq_o), m_seq);
  endtask

  // Check combinational outputs for the inputs now applied; prepare next record.
  task automatic check_lanes();
    int used = 0;
    bit bv = 0;
    int bs = 0;
    for (int i = 0; i < LANES; i++) begin
      bit e_iss = 0, e_cmd = 0, e_res = 0, e_flt = 0, e_blk = 0;
      bit at_head = (lane_idx(i) == int'(lq_head));
      if (ld_valid[i]) begin
        if (ld_uncached[i] && !(at_head && ld_at_commit[i])) begin
          e_res = 1; e_flt = 1;
        end else if (used == PORTS) begin
          e_res = 1;
        end else begin
          used++;
          if (cache_blocked) e_blk = 1;
          else begin e_iss = 1; e_cmd = ld_locked[i]; end
        end
      end
      if (!ld_valid[i]) begin
        chk({issue_o[i], resched_o[i], blocked_o[i], fault_o[i], cmd_locked_o[i]} == 5'b0,
            "R12 idle lane quiet", int'({issue_o[i], resched_o[i], blocked_o[i]}), 0);
      end else begin
        chk(fault_o[i] == e_flt, (ld_uncached[i] ? "R1 uncached fault" : "R2 cacheable fault"),
            int'(fault_o[i]), int'(e_flt));
        chk(resched_o[i] == e_res, "R4 resched", int'(resched_o[i]), int'(e_res));
        chk(issue_o[i] == e_iss, "R5 issue", int'(issue_o[i]), int'(e_iss));
        chk(blocked_o[i] == e_blk, "R5 blocked", int'(blocked_o[i]), int'(e_blk));
        chk(cmd_locked_o[i] == e_cmd, "R3 command", int'(cmd_locked_o[i]), int'(e_cmd));
      end
      if (e_blk && (!bv || lane_seq(i) < bs)) begin
        bv = 1; bs = lane_seq(i);
      end
    end
    chk(int'(used_ports_o) == used, "R4 used ports", int'(used_ports_o), used);
    chk(full_o == ((int'(lq_count) >= SLOTS-1) || (int'(sq_count) >= SLOTS-1)),
        "R10 full", int'(full_o), int'((int'(lq_count) >= SLOTS-1) || (int'(sq_count) >= SLOTS-1)));
    n_flag = m_flag; n_hand = m_hand; n_seq = m_seq;
    if (bv) begin
      if (!(m_flag && m_seq < bs)) begin
        n_flag = 1; n_hand = 0; n_seq = bs;
      end
    end else begin
      if (blk_clear) n_flag = 0;
      if (blk_set_handled && m_flag) n_hand = 1;
    end
  endtask

  task automatic set_lane(input int i, input bit v, input int idx, input int sq,
                          input bit uc, input bit atc, input bit lk);
    ld_valid[i] = v;
    ld_idx[i*IDXW +: IDXW] = IDXW'(idx);
    ld_seq[i*SEQW +: SEQW] = SEQW'(sq);
    ld_uncached[i] = uc;
    ld_at_commit[i] = atc;
    ld_locked[i] = lk;
  endtask

  // One cycle: at negedge advance model, check record, apply inputs, check lanes.
  task automatic step(input string tag);
    @(negedge clk);
    m_flag = n_flag; m_hand = n_hand; m_seq = n_seq;
    check_record(tag);
    #1;
    check_lanes();
  endtask

  task automatic apply_and_step(input string tag);
    // inputs already set before negedge are not allowed: set after negedge
    step(tag);
  endtask

  task automatic idle_inputs();
    ld_valid = '0; blk_clear = 0; blk_set_handled = 0; cache_blocked = 0;
  endtask

  // Directed cycle: wait for negedge, update model, check record, then drive and check.
  task automatic directed(input string tag);
    m_flag = n_flag; m_hand = n_hand; m_seq = n_seq;
    check_record(tag);
    #1;
    check_lanes();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk(blk_flag_o == 0, "R11 reset flag", int'(blk_flag_o), 0);
    chk(blk_handled_o == 0, "R11 reset handled", int'(blk_handled_o), 0);
    chk(blk_seq_o == 0, "R11 reset seq", int'(blk_seq_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: R2 uncached at head and at commit issues as locked
    @(negedge clk);
    idle_inputs(); lq_head = 4'd5;
    set_lane(0, 1, 5, 10, 1, 1, 1);
    set_lane(1, 1, 6, 11, 1, 1, 0);
    set_lane(2, 1, 7, 12, 0, 0, 0);
    directed("R2 head uncached");
    chk(issue_o[0] == 1 && cmd_locked_o[0] == 1, "R2 R3 head uncached locked issue",
        int'({issue_o[0], cmd_locked_o[0]}), 3);
    chk(fault_o[1] == 1, "R1 away from head", int'(fault_o[1]), 1);

    // Directed: three valid loads, two ports: lane 2 replayed without fault (R4)
    @(negedge clk);
    idle_inputs();
    set_lane(0, 1, 1, 20, 0, 0, 0);
    set_lane(1, 1, 2, 21, 0, 0, 1);
    set_lane(2, 1, 3, 22, 0, 0, 0);
    directed("R4 ports");
    chk(resched_o[2] == 1 && fault_o[2] == 0, "R4 third lane no port",
        int'({resched_o[2], fault_o[2]}), 2);

    // Directed: blocked lanes with seq 40 and 20 -> record 20 (R6)
    @(negedge clk);
    idle_inputs(); cache_blocked = 1;
    set_lane(0, 1, 1, 40, 0, 0, 0);
    set_lane(1, 1, 2, 20, 0, 0, 0);
    directed("R5 block");
    @(negedge clk);
    idle_inputs(); cache_blocked = 1;
    set_lane(0, 1, 1, 30, 0, 0, 0);   // younger: must not overwrite (R7)
    blk_clear = 1;                    // ignored with a block this cycle (R8)
    directed("R6 record oldest");
    chk(blk_seq_o == 8'd20, "R6 oldest recorded", int'(blk_seq_o), 20);
    @(negedge clk);
    idle_inputs(); blk_set_handled = 1;
    directed("R7 keep older");
    chk(blk_seq_o == 8'd20 && blk_flag_o, "R7 older kept", int'(blk_seq_o), 20);
    @(negedge clk);
    idle_inputs(); cache_blocked = 1;
    set_lane(0, 1, 1, 20, 0, 0, 0);   // equal tag overwrites, clears handled
    directed("R9 handled set");
    chk(blk_handled_o == 1, "R9 handled set", int'(blk_handled_o), 1);
    @(negedge clk);
    idle_inputs(); blk_clear = 1;
    directed("R6 equal overwrite");
    chk(blk_handled_o == 0, "R6 handled cleared by new block", int'(blk_handled_o), 0);
    @(negedge clk);
    idle_inputs(); blk_set_handled = 1;
    directed("R8 cleared");
    chk(blk_flag_o == 0, "R8 flag dropped", int'(blk_flag_o), 0);
    @(negedge clk);
    idle_inputs();
    directed("R9 no effect when empty");
    chk(blk_handled_o == 0, "R9 set ignored while empty", int'(blk_handled_o), 0);

    // Directed: full boundaries (R10)
    for (int c = 13; c <= 16; c++) begin
      @(negedge clk);
      idle_inputs(); lq_count = LCW'(c); sq_count = '0;
      directed("R10 lq boundary");
      @(negedge clk);
      idle_inputs(); lq_count = '0; sq_count = LCW'(c);
      directed("R10 sq boundary");
    end

    // Random phases
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 700; n++) begin
        @(negedge clk);
        lq_head = IDXW'($urandom_range(0, 3));
        cache_blocked = (ph == 1 || ph == 3) ? ($urandom_range(0, 9) < 7) : ($urandom_range(0, 9) < 2);
        for (int i = 0; i < LANES; i++)
          set_lane(i, $urandom_range(0, 3) != 0, $urandom_range(0, 3),
                   (ph >= 2) ? $urandom_range(0, 7) : $urandom_range(0, 255),
                   $urandom_range(0, 2) == 0, $urandom_range(0, 1), $urandom_range(0, 1));
        blk_clear = ($urandom_range(0, 7) == 0);
        blk_set_handled = ($urandom_range(0, 3) == 0);
        lq_count = LCW'($urandom_range(0, 16));
        sq_count = LCW'($urandom_range(0, 16));
        directed("R6 R7 random");
      end
    end

    @(negedge clk);
    idle_inputs();
    directed("R8 final");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule